// File: doc/BRIEF.md
# Multi-Enable Interrupt Controller

This block gathers a fixed set of level-sensitive interrupt sources into a single CPU interrupt request. Each source is gated by every enable that software has assigned to it: single-bit entries in mask registers and multi-bit fields in priority registers. A source counts as enabled only when all of its assigned enables are on. A priority field is on whenever it is non-zero. One source may therefore depend on two or three registers at once.

Software reaches the registers over a simple single-cycle bus. Most registers have a set address and a clear address. A write to the set address ORs the data into the register. A write to the clear address clears each bit written as one. One priority register has a single plain-write address instead. The CPU reads the vector of the lowest-numbered pending source from a combinational lookup port, and it supplies its current interrupt mask level alongside the lookup.

Top module: `mei_intc`

## Requirements
- R1: While reset is applied and on the first cycle after it, `irq_o` and `vec_valid_o` are low, and every register reads back as zero.
- R2: A write to a set address (mask register 0 at 0x40, mask register 1 at 0x48, priority register 1 at 0x10) ORs the write data into the stored value. The stored value is updated on the clock edge that samples the write.
- R3: A write to a clear address (0x44, 0x4C, 0x14 for the same three registers) clears each stored bit that is written as one and leaves all other stored bits unchanged.
- R4: A write to the plain address of priority register 0 (0x20) replaces its whole stored value with the 32-bit write data.
- R5: Mask registers are 16 bits wide (write data bits 15:0). Entry k of a mask register is bit 15-k. In mask register 0, entry k gates source k for k = 0..15. In mask register 1, entry k gates source 8+k for k = 0..7; entries 8..15 gate nothing.
- R6: Priority registers are 32 bits wide and hold eight 4-bit fields. Field f occupies bits [31-4f : 28-4f]. In priority register 0, field f gates source f for f = 0..7. In priority register 1, field f gates source 12+f for f = 0..3; fields 4..7 gate nothing. A field enables its source when the field is non-zero.
- R7: Source s becomes pending on the clock edge after its level input is high while all of its enables are on. It stops being pending on the edge after either condition fails. Sources 12..15 need three enables; every other source needs two.
- R8: `irq_o` is high exactly while at least one source is pending.
- R9: `vec_valid_o` is high when a source is pending and `cpu_imask_i` is not 0xF. `vec_o` then equals 0x200 + 0x20 × (lowest pending source index).
- R10: Address decode uses only bits 28:0 of `bus_addr_i`, so bits 31:29 have no effect.
- R11: `bus_rdata_o` shows the stored value, zero-extended, of the register addressed in the same cycle. Both addresses of a pair read the same register. An unmapped address reads zero, and a write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 32 | Bus address |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| src_level_i | input | 16 | Level input of each source |
| cpu_imask_i | input | 4 | CPU interrupt mask level |
| irq_o | output | 1 | CPU interrupt request |
| vec_valid_o | output | 1 | A vector is being returned |
| vec_o | output | 12 | Vector of the lowest pending source |

## Verification
The bench builds the block with its default parameters: 16 sources, 16-bit mask registers, and 32-bit priority registers with 4-bit fields. With that build the default mapping reaches every enable arrangement: sources gated by a mask bit plus a priority field, sources gated by two mask bits, and sources gated by three enables. It also reaches the unmapped entries in mask register 1 and the unmapped fields in priority register 1. Random writes land on all seven register addresses and on unmapped addresses, with random upper address bits. This drives both set/clear pairs and the plain-write register through OR, clear and overwrite sequences. A field that changes between two non-zero values is also exercised, as is the imask level 0xF.

// File: rtl/mei_pkg.sv
// Package: shared register map and source mapping for the multi-enable
// interrupt controller. Assumes at most 2 mask and 2 priority registers.
package mei_pkg;

    localparam int NO_SRC      = -1;
    localparam int N_MASK_REGS = 2;
    localparam int N_PRIO_REGS = 2;

    // Set address of mask register r.
    function automatic logic [31:0] mask_set_addr(input int r);
        return 32'h40 + 32'(r * 8);
    endfunction

    // Clear address of mask register r.
    function automatic logic [31:0] mask_clr_addr(input int r);
        return 32'h44 + 32'(r * 8);
    endfunction

    // Primary (set or plain) address of priority register r.
    function automatic logic [31:0] prio_set_addr(input int r);
        return (r == 0) ? 32'h20 : 32'h10;
    endfunction

    // Clear address of priority register r (only meaningful with a pair).
    function automatic logic [31:0] prio_clr_addr(input int r);
        return (r == 0) ? 32'h24 : 32'h14;
    endfunction

    // Whether priority register r has a set/clear pair.
    function automatic bit prio_has_clr(input int r);
        return r != 0;
    endfunction

    // Source gated by entry k (MSB first) of mask register r.
    function automatic int mask_src(input int r, input int k, input int n_src);
        int s;
        if (r == 0)      s = k;
        else if (k < 8)  s = 8 + k;
        else             s = NO_SRC;
        return (s >= 0 && s < n_src) ? s : NO_SRC;
    endfunction

    // Source gated by field f (MSB first) of priority register r.
    function automatic int prio_src(input int r, input int f, input int n_src);
        int s;
        if (r == 0)      s = f;
        else if (f < 4)  s = 12 + f;
        else             s = NO_SRC;
        return (s >= 0 && s < n_src) ? s : NO_SRC;
    endfunction

endpackage

// File: rtl/mei_cfg_reg.sv
// Module: one configuration register with either a set/clear address pair
// (OR on set, clear-on-one on clear) or a single plain-write address.
// Assumes addresses are compared on their low MATCH_W bits only.
module mei_cfg_reg #(
    parameter int          W        = 16,
    parameter int          MATCH_W  = 29,
    parameter logic [31:0] SET_ADDR = 32'h0,
    parameter logic [31:0] CLR_ADDR = 32'h4,
    parameter bit          HAS_CLR  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MATCH_W-1:0] addr_i,
    input  logic               we_i,
    input  logic [W-1:0]       wdata_i,
    output logic [W-1:0]       value_o,
    output logic               hit_o
);

    localparam logic [MATCH_W-1:0] SET_M = SET_ADDR[MATCH_W-1:0];
    localparam logic [MATCH_W-1:0] CLR_M = CLR_ADDR[MATCH_W-1:0];

    logic set_hit;
    logic clr_hit;

    // Address match for each of the register's addresses.
    always_comb begin
        set_hit = (addr_i == SET_M);
        clr_hit = HAS_CLR && (addr_i == CLR_M);
        hit_o   = set_hit || clr_hit;
    end

    // Store update: plain overwrite, OR on set, clear-on-one on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_o <= '0;
        end else if (we_i && set_hit) begin
            value_o <= HAS_CLR ? (value_o | wdata_i) : wdata_i;
        end else if (we_i && clr_hit) begin
            value_o <= value_o & ~wdata_i;
        end
    end

endmodule

// File: rtl/mei_enable_map.sv
// Module: folds every mask bit and priority field onto its source.
// A source is enabled only when all enables mapped to it are on.
// Assumes the mapping functions of mei_pkg; a source without any
// mapping is treated as always enabled.
module mei_enable_map
    import mei_pkg::*;
#(
    parameter int N_SRC   = 16,
    parameter int MASK_W  = 16,
    parameter int PRIO_W  = 32,
    parameter int FIELD_W = 4
) (
    input  logic [N_MASK_REGS-1:0][MASK_W-1:0] mask_i,
    input  logic [N_PRIO_REGS-1:0][PRIO_W-1:0] prio_i,
    output logic [N_SRC-1:0]                   en_o
);

    localparam int N_FIELDS = PRIO_W / FIELD_W;

    // AND together every enable assigned to each source.
    always_comb begin
        en_o = '1;
        for (int r = 0; r < N_MASK_REGS; r++) begin
            for (int k = 0; k < MASK_W; k++) begin
                for (int s = 0; s < N_SRC; s++) begin
                    if (mask_src(r, k, N_SRC) == s) begin
                        en_o[s] = en_o[s] & mask_i[r][MASK_W-1-k];
                    end
                end
            end
        end
        for (int r = 0; r < N_PRIO_REGS; r++) begin
            for (int f = 0; f < N_FIELDS; f++) begin
                for (int s = 0; s < N_SRC; s++) begin
                    if (prio_src(r, f, N_SRC) == s) begin
                        en_o[s] = en_o[s] &
                                  (|prio_i[r][PRIO_W-1-f*FIELD_W -: FIELD_W]);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mei_vec_pick.sv
// Module: returns the vector of the lowest-indexed pending source.
// Assumes vectors are VEC_BASE + index * VEC_STEP and fit VEC_W bits.
module mei_vec_pick #(
    parameter int N_SRC    = 16,
    parameter int VEC_W    = 12,
    parameter int VEC_BASE = 512,
    parameter int VEC_STEP = 32,
    parameter int IMASK_W  = 4
) (
    input  logic [N_SRC-1:0]   pend_i,
    input  logic [IMASK_W-1:0] imask_i,
    output logic               valid_o,
    output logic [VEC_W-1:0]   vec_o
);

    int idx;

    // Scan from the top so the lowest pending index wins.
    always_comb begin
        idx = 0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) idx = i;
        end
    end

    // Suppress the vector at the fully masked level or with nothing pending.
    always_comb begin
        valid_o = (|pend_i) && (imask_i != '1);
        vec_o   = valid_o ? VEC_W'(VEC_BASE + idx * VEC_STEP) : '0;
    end

endmodule

// File: rtl/mei_intc.sv
// Module: top of the multi-enable interrupt controller. Holds mask and
// priority registers, registers per-source pending state, drives the
// CPU request and serves vector lookups and register reads.
// Assumes a single-cycle bus and DATA_W no smaller than MASK_W or PRIO_W.
module mei_intc
    import mei_pkg::*;
#(
    parameter int N_SRC    = 16,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int MATCH_W  = 29,
    parameter int MASK_W   = 16,
    parameter int PRIO_W   = 32,
    parameter int FIELD_W  = 4,
    parameter int VEC_W    = 12,
    parameter int VEC_BASE = 512,
    parameter int VEC_STEP = 32,
    parameter int IMASK_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_we_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    input  logic [N_SRC-1:0]   src_level_i,
    input  logic [IMASK_W-1:0] cpu_imask_i,
    output logic               irq_o,
    output logic               vec_valid_o,
    output logic [VEC_W-1:0]   vec_o
);

    localparam int CNT_W = $clog2(N_SRC + 1);

    logic [N_MASK_REGS-1:0][MASK_W-1:0] mask_q;
    logic [N_PRIO_REGS-1:0][PRIO_W-1:0] prio_q;
    logic [N_MASK_REGS-1:0]             mask_hit;
    logic [N_PRIO_REGS-1:0]             prio_hit;
    logic [N_SRC-1:0]                   src_en;
    logic [N_SRC-1:0]                   pend_q;
    logic [CNT_W-1:0]                   pend_cnt;
    logic [MATCH_W-1:0]                 addr_lo;
    logic                               unused_addr_hi;

    assign addr_lo        = bus_addr_i[MATCH_W-1:0];
    assign unused_addr_hi = ^bus_addr_i[ADDR_W-1:MATCH_W];

    for (genvar r = 0; r < N_MASK_REGS; r++) begin : g_mask
        mei_cfg_reg #(
            .W        (MASK_W),
            .MATCH_W  (MATCH_W),
            .SET_ADDR (mask_set_addr(r)),
            .CLR_ADDR (mask_clr_addr(r)),
            .HAS_CLR  (1'b1)
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr_i  (addr_lo),
            .we_i    (bus_we_i),
            .wdata_i (bus_wdata_i[MASK_W-1:0]),
            .value_o (mask_q[r]),
            .hit_o   (mask_hit[r])
        );
    end

    for (genvar r = 0; r < N_PRIO_REGS; r++) begin : g_prio
        mei_cfg_reg #(
            .W        (PRIO_W),
            .MATCH_W  (MATCH_W),
            .SET_ADDR (prio_set_addr(r)),
            .CLR_ADDR (prio_clr_addr(r)),
            .HAS_CLR  (prio_has_clr(r))
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr_i  (addr_lo),
            .we_i    (bus_we_i),
            .wdata_i (bus_wdata_i[PRIO_W-1:0]),
            .value_o (prio_q[r]),
            .hit_o   (prio_hit[r])
        );
    end

    mei_enable_map #(
        .N_SRC   (N_SRC),
        .MASK_W  (MASK_W),
        .PRIO_W  (PRIO_W),
        .FIELD_W (FIELD_W)
    ) u_map (
        .mask_i (mask_q),
        .prio_i (prio_q),
        .en_o   (src_en)
    );

    // Per-source pending: level high and every mapped enable on.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= src_level_i & src_en;
    end

    // Pending count drives the CPU request.
    always_comb begin
        pend_cnt = CNT_W'($countones(pend_q));
        irq_o    = (pend_cnt != '0);
    end

    mei_vec_pick #(
        .N_SRC    (N_SRC),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP),
        .IMASK_W  (IMASK_W)
    ) u_pick (
        .pend_i  (pend_q),
        .imask_i (cpu_imask_i),
        .valid_o (vec_valid_o),
        .vec_o   (vec_o)
    );

    // Read mux: stored value of the addressed register, zero otherwise.
    always_comb begin
        bus_rdata_o = '0;
        for (int r = 0; r < N_MASK_REGS; r++) begin
            if (mask_hit[r]) bus_rdata_o = DATA_W'(mask_q[r]);
        end
        for (int r = 0; r < N_PRIO_REGS; r++) begin
            if (prio_hit[r]) bus_rdata_o = DATA_W'(prio_q[r]);
        end
    end

endmodule

// File: rtl/mei_intc_checker.sv
// Module: assertion checker for mei_intc, attached by bind below.
// Assumes the default register map of mei_pkg.
module mei_intc_checker
    import mei_pkg::*;
#(
    parameter int N_SRC   = 16,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int MATCH_W = 29,
    parameter int MASK_W  = 16,
    parameter int PRIO_W  = 32,
    parameter int IMASK_W = 4
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [ADDR_W-1:0]                  bus_addr_i,
    input logic                               bus_we_i,
    input logic [DATA_W-1:0]                  bus_wdata_i,
    input logic [N_SRC-1:0]                   src_level_i,
    input logic [IMASK_W-1:0]                 cpu_imask_i,
    input logic                               irq_o,
    input logic                               vec_valid_o,
    input logic [N_MASK_REGS-1:0][MASK_W-1:0] mask_q,
    input logic [N_PRIO_REGS-1:0][PRIO_W-1:0] prio_q,
    input logic [N_SRC-1:0]                   pend_q
);

    logic [MATCH_W-1:0] a;
    logic               any_hit;

    // Independent address decode for the unmapped-write property.
    always_comb begin
        a = bus_addr_i[MATCH_W-1:0];
        any_hit = 1'b0;
        for (int r = 0; r < N_MASK_REGS; r++) begin
            if (a == mask_set_addr(r)[MATCH_W-1:0] ||
                a == mask_clr_addr(r)[MATCH_W-1:0]) any_hit = 1'b1;
        end
        for (int r = 0; r < N_PRIO_REGS; r++) begin
            if (a == prio_set_addr(r)[MATCH_W-1:0] ||
                (prio_has_clr(r) && a == prio_clr_addr(r)[MATCH_W-1:0]))
                any_hit = 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !vec_valid_o && mask_q == '0 && prio_q == '0));

    a_r2_set_ors: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && a == mask_set_addr(0)[MATCH_W-1:0])
        |=> mask_q[0] == ($past(mask_q[0]) | $past(bus_wdata_i[MASK_W-1:0])));

    a_r3_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && a == mask_clr_addr(1)[MATCH_W-1:0])
        |=> mask_q[1] == ($past(mask_q[1]) & ~$past(bus_wdata_i[MASK_W-1:0])));

    a_r4_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && a == prio_set_addr(0)[MATCH_W-1:0])
        |=> prio_q[0] == $past(bus_wdata_i[PRIO_W-1:0]));

    a_r7_pend_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend_q & ~$past(src_level_i)) == '0);

    a_r9_vec_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> irq_o);

    a_r9_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_imask_i == '1) |-> !vec_valid_o);

    a_r11_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && !any_hit) |=> ($stable(mask_q) && $stable(prio_q)));

endmodule

bind mei_intc mei_intc_checker #(
    .N_SRC   (N_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MATCH_W (MATCH_W),
    .MASK_W  (MASK_W),
    .PRIO_W  (PRIO_W),
    .IMASK_W (IMASK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .src_level_i (src_level_i),
    .cpu_imask_i (cpu_imask_i),
    .irq_o       (irq_o),
    .vec_valid_o (vec_valid_o),
    .mask_q      (mask_q),
    .prio_q      (prio_q),
    .pend_q      (pend_q)
);

// File: tb/mei_intc_test.sv
module mei_intc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr_i = '0;
    logic        bus_we_i = 1'b0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [15:0] src_level_i = '0;
    logic [3:0]  cpu_imask_i = '0;
    logic        irq_o;
    logic        vec_valid_o;
    logic [11:0] vec_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference state, built from the requirements.
    logic [15:0] m_mask [2];
    logic [31:0] m_prio [2];
    logic [15:0] m_pend;

    always #5 clk = ~clk;

    mei_intc uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (bus_addr_i),
        .bus_we_i    (bus_we_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .src_level_i (src_level_i),
        .cpu_imask_i (cpu_imask_i),
        .irq_o       (irq_o),
        .vec_valid_o (vec_valid_o),
        .vec_o       (vec_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // R5/R6 enable rule per source.
    function automatic bit m_enabled(input int s);
        bit e;
        e = m_mask[0][15-s];
        if (s < 8)       e = e & (m_prio[0][31-4*s -: 4] != 0);
        else if (s < 12) e = e & m_mask[1][15-(s-8)];
        else             e = e & m_mask[1][15-(s-8)] & (m_prio[1][31-4*(s-12) -: 4] != 0);
        return e;
    endfunction

    function automatic logic [31:0] m_read(input logic [31:0] addr);
        case (addr[28:0])
            29'h40, 29'h44: return {16'h0, m_mask[0]};
            29'h48, 29'h4C: return {16'h0, m_mask[1]};
            29'h20:         return m_prio[0];
            29'h10, 29'h14: return m_prio[1];
            default:        return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [31:0] addr);
        case (addr[28:0])
            29'h40, 29'h48, 29'h10: return "R2 set/read";
            29'h44, 29'h4C, 29'h14: return "R3 clear/read";
            29'h20:                 return "R4 plain/read";
            default:                return "R11 unmapped read";
        endcase
    endfunction

    task automatic m_write(input logic [31:0] addr, input logic [31:0] d);
        case (addr[28:0])
            29'h40: m_mask[0] = m_mask[0] | d[15:0];
            29'h44: m_mask[0] = m_mask[0] & ~d[15:0];
            29'h48: m_mask[1] = m_mask[1] | d[15:0];
            29'h4C: m_mask[1] = m_mask[1] & ~d[15:0];
            29'h20: m_prio[0] = d;
            29'h10: m_prio[1] = m_prio[1] | d;
            29'h14: m_prio[1] = m_prio[1] & ~d;
            default: ;
        endcase
    endtask

    task automatic check_outputs();
        bit ev;
        int low;
        low = -1;
        for (int s = 15; s >= 0; s--) if (m_pend[s]) low = s;
        ev = (m_pend != 0) && (cpu_imask_i != 4'hF);
        chk("R8 irq", {31'h0, irq_o}, {31'h0, m_pend != 0});
        chk("R9 valid", {31'h0, vec_valid_o}, {31'h0, ev});
        if (ev) chk("R9 vector", {20'h0, vec_o}, 32'(512 + 32 * low));
        chk(rd_tag(bus_addr_i), bus_rdata_o, m_read(bus_addr_i));
    endtask

    // One bus cycle: drive at negedge, update model, check at next negedge.
    task automatic step(input logic [31:0] addr, input bit we, input logic [31:0] d,
                        input logic [15:0] src, input logic [3:0] imask);
        logic [15:0] pn;
        bus_addr_i  = addr;
        bus_we_i    = we;
        bus_wdata_i = d;
        src_level_i = src;
        cpu_imask_i = imask;
        for (int s = 0; s < 16; s++) pn[s] = src[s] & m_enabled(s);
        m_pend = pn;
        if (we) m_write(addr, d);
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    function automatic logic [31:0] pick_addr(input int r);
        logic [31:0] lo;
        case (r % 9)
            0: lo = 32'h40; 1: lo = 32'h44; 2: lo = 32'h48; 3: lo = 32'h4C;
            4: lo = 32'h20; 5: lo = 32'h10; 6: lo = 32'h14; 7: lo = 32'h24;
            default: lo = 32'h18;
        endcase
        return {3'($urandom), lo[28:0]};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        m_mask[0] = '0; m_mask[1] = '0; m_prio[0] = '0; m_prio[1] = '0; m_pend = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on every address, lines high but nothing enabled.
        foreach (m_mask[i]) ;
        for (int r = 0; r < 9; r++) step(pick_addr(r), 1'b0, '0, 16'hFFFF, 4'h0);
        chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
        // R5 R6 R7: source 3 via mask0 bit 12 and prio0 field 3 (bits 19:16).
        step(32'h40, 1'b1, 32'h0000_1000, 16'h0008, 4'h0);
        step(32'h20, 1'b1, 32'h0001_0000, 16'h0008, 4'h0);
        step(32'h20, 1'b0, 32'h0,         16'h0008, 4'h0);
        chk("R7 source 3 vector", {20'h0, vec_o}, 32'h260);
        // R7: source 12 needs mask0 bit 3, mask1 bit 11, prio1 field 0.
        step(32'h40, 1'b1, 32'h0000_0008, 16'h1000, 4'h0);
        step(32'h48, 1'b1, 32'h0000_0800, 16'h1000, 4'h0);
        step(32'h48, 1'b0, 32'h0,         16'h1000, 4'h0);
        chk("R7 two of three enables", {31'h0, irq_o}, 32'h0);
        step(32'h10, 1'b1, 32'h1000_0000, 16'h1000, 4'h0);
        step(32'h10, 1'b0, 32'h0,         16'h1000, 4'h0);
        chk("R7 all three enables", {20'h0, vec_o}, 32'h380);
        // R6: field goes from 1 to 3, stays enabled.
        step(32'h10, 1'b1, 32'h2000_0000, 16'h1000, 4'h0);
        step(32'h10, 1'b0, 32'h0,         16'h1000, 4'h0);
        chk("R6 nonzero field keeps enable", {31'h0, irq_o}, 32'h1);
        // R9: full mask hides vector but request stays.
        step(32'h10, 1'b0, 32'h0, 16'h1000, 4'hF);
        chk("R9 imask 0xF", {31'h0, vec_valid_o}, 32'h0);
        // R10: upper address bits ignored.
        step(32'hE000_004C, 1'b1, 32'h0000_0800, 16'h1000, 4'h0);
        step(32'h0000_0048, 1'b0, 32'h0, 16'h1000, 4'h0);
        chk("R10 high bits ignored", bus_rdata_o, 32'h0);
        step(32'h0000_0048, 1'b0, 32'h0, 16'h1000, 4'h0);
        chk("R10 source 12 dropped", {31'h0, irq_o}, 32'h0);
        // R11: unmapped write ignored.
        step(32'h0000_0100, 1'b1, 32'hFFFF_FFFF, 16'hFFFF, 4'h0);
        step(32'h0000_0040, 1'b0, 32'h0, 16'hFFFF, 4'h0);
        chk("R11 unmapped write ignored", bus_rdata_o, 32'h0000_1008);
        // Random traffic with biased-high data to reach pending states.
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] d;
            int r;
            r = int'($urandom % 9);
            d = ($urandom % 3 == 0) ? $urandom : ($urandom | $urandom);
            step(pick_addr(r), ($urandom % 2) == 0, d, 16'($urandom | $urandom),
                 ($urandom % 5 == 0) ? 4'hF : 4'($urandom));
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule